// File: doc/BRIEF.md
# Serial Memory Command Master

This block drives a four-wire serial bus to run one complete memory-style operation per request. Each operation starts with an 8-bit opcode, may carry an address of one, two or three bytes, and ends with zero or more data bytes that are sent and received at the same time. The clock idle level, the sampling phase and the chip-select polarity come from a small mode word presented with the request, so one master can talk to parts wired for any of the four clock modes and to parts with an active-high select.

A request is taken when `req` is high while the block is idle. The opcode, address, address size, address-folding flag and byte count are captured at that moment. During the data phase the block pulls transmit bytes one at a time with `tx_take` and hands back each received byte with a one-cycle `rx_valid`. When select has been released, `done` pulses for one cycle. For small parts whose ninth address bit lives inside the opcode, a folding option puts address bit 8 into opcode bit 3 and sends only one address byte.

Top module: `spi_mem_master`

## Requirements
- R1: After reset `cs` is 1, `sclk` is 0 and `done`, `busy`, `rx_valid` and `tx_take` are 0. While the block is idle, `sclk` follows `mode[1]` and `cs` follows the inactive level `~mode[4]`, each one cycle later.
- R2: On `mosi` every byte goes out most significant bit first, in this order: the opcode, then the address bytes, then `data_len` transmit bytes. `addr_sel` picks the address size: 0 for none, 1 for `addr[7:0]`, 2 for `addr[15:0]`, 3 for `addr[23:0]`. Higher address bytes are sent first.
- R3: When `munge` is 1 and `addr_sel` is not 0, the opcode is sent with bit 3 set to `cmd[3] | addr[8]`, and the address phase is the single byte `addr[7:0]`.
- R4: `mode[1]` sets the idle level of `sclk`. With `mode[0]`=0 the slave samples `mosi` on the edge leaving idle and data changes on the edge returning to idle. With `mode[0]`=1 this is reversed. The master samples `miso` on the same edge on which the slave samples `mosi`.
- R5: With `mode[4]`=1 the select line `cs` is driven high while active. With `mode[4]`=0 it is driven low while active.
- R6: Each data byte received on `miso` (MSB first) appears on `rx_data` with `rx_valid` high for one cycle. There are exactly `data_len` such pulses per operation and none for opcode or address bytes.
- R7: `tx_take` is high once per transmit byte, in the cycle in which `tx_data` is captured. It happens exactly `data_len` times per operation.
- R8: A `data_len` of 0 runs only the opcode and address phases: 8 × (1 + address bytes) clock periods.
- R9: Every `sclk` half period lasts `CLK_DIV/2` system cycles. Select is active at least `CLK_DIV/2` cycles before the first `sclk` edge and stays active at least `CLK_DIV/2` cycles after the last one.
- R10: `done` is high for exactly one cycle, starting one cycle after `cs` returns to its inactive level. `busy` is high from the cycle after a request is taken until `done`.
- R11: A `req` that arrives while `busy` is high is ignored. A `req` in the cycle in which `done` is high is taken, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an operation while idle |
| mode | input | 5 | Bit 0 phase, bit 1 clock idle level, bit 4 active-high select; bits 3:2 unused |
| cmd | input | 8 | Opcode byte |
| addr | input | 24 | Address value |
| addr_sel | input | 2 | Address size: 0 none, 1/2/3 bytes |
| munge | input | 1 | Fold address bit 8 into opcode bit 3 |
| data_len | input | LEN_W | Number of data bytes |
| tx_data | input | 8 | Transmit byte, captured when tx_take is high |
| tx_take | output | 1 | Transmit byte consumed this cycle |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | rx_data updated |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. When that happens, the select line has to leave its inactive level again straight away, and the new opcode must not be mixed with the old frame. The bench provokes this by raising `req` in the cycle in which it sees `done`. A bus-side slave model then checks the second frame bit by bit. It also checks that `done` was seen exactly one cycle after select was released. A second overlap, a stray `req` in the middle of a frame carrying an inverted opcode, is judged by the same frame comparison and by counting a single completion.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 24;
   localparam int BIT_PHA = 0;
   localparam int BIT_POL = 1;
   localparam int BIT_CSH = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SHIFT,
      ST_HOLD,
      ST_FIN
   } spi_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF < 1) begin : g_bad
         $error("spi_half_timer: HALF must be at least 1");
      end
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int W = $clog2(HALF);
         logic [W-1:0] cnt;
         assign tick = run && (cnt == W'(HALF - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!run || tick)  cnt <= '0;
            else                    cnt <= cnt + W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/spi_frame_build.sv
module spi_frame_build
   import spi_mem_pkg::*;
(
   input  logic [BYTE_W-1:0] cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        addr_sel,
   input  logic              munge,
   input  logic              nxt_addr,
   input  logic [BYTE_W-1:0] addr_hi,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] cmd_eff,
   output logic [1:0]        nab,
   output logic [ADDR_W-1:0] addr_al,
   output logic [BYTE_W-1:0] nxt_byte
);
   logic fold;
   assign fold     = munge && (addr_sel != 2'd0);
   assign cmd_eff  = cmd | {4'b0000, fold && addr[8], 3'b000};
   assign nab      = (addr_sel == 2'd0) ? 2'd0 : (fold ? 2'd1 : addr_sel);
   assign nxt_byte = nxt_addr ? addr_hi : tx_data;

   always_comb begin
      case (nab)
         2'd1:    addr_al = {addr[7:0], 16'h0000};
         2'd2:    addr_al = {addr[15:0], 8'h00};
         2'd3:    addr_al = addr;
         default: addr_al = '0;
      endcase
   end
endmodule

// File: rtl/spi_mem_master.sv
module spi_mem_master
   import spi_mem_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int LEN_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [4:0]       mode,
   input  logic [7:0]       cmd,
   input  logic [23:0]      addr,
   input  logic [1:0]       addr_sel,
   input  logic             munge,
   input  logic [LEN_W-1:0] data_len,
   input  logic [7:0]       tx_data,
   output logic             tx_take,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   output logic             busy,
   output logic             done,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso,
   output logic             cs
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = LEN_W + 2;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("spi_mem_master: CLK_DIV must be even and at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("spi_mem_master: LEN_W must be at least 1");
      end
   endgenerate

   spi_state_e        state;
   logic              cpol_r, cpha_r, csh_r;
   logic [1:0]        nab_r;
   logic [CW-1:0]     total_r, bidx;
   logic [ADDR_W-1:0] addr_sh;
   logic [7:0]        sreg, rx_sh, rx_q;
   logic [2:0]        bitc;
   logic              half_b, sclk_q, cs_q, rxv_q, done_q;
   logic              tick, run;
   logic              nxt_addr, cur_data, last_byte, byte_end;
   logic [7:0]        cmd_eff, nxt_byte;
   logic [1:0]        nab_w;
   logic [ADDR_W-1:0] addr_al;
   logic              mode_unused;

   assign mode_unused = ^mode[3:2];

   assign run       = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);
   assign nxt_addr  = (bidx + CW'(1)) <= CW'(nab_r);
   assign cur_data  = bidx > CW'(nab_r);
   assign last_byte = (bidx == total_r - CW'(1));
   assign byte_end  = (state == ST_SHIFT) && tick && half_b && (bitc == 3'd7);

   assign tx_take  = byte_end && !last_byte && !nxt_addr;
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign rx_valid = rxv_q;
   assign rx_data  = rx_q;
   assign sclk     = sclk_q;
   assign cs       = cs_q;
   assign mosi     = sreg[7];

   spi_half_timer #(.HALF(HALF)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   spi_frame_build u_build (
      .cmd      (cmd),
      .addr     (addr),
      .addr_sel (addr_sel),
      .munge    (munge),
      .nxt_addr (nxt_addr),
      .addr_hi  (addr_sh[23:16]),
      .tx_data  (tx_data),
      .cmd_eff  (cmd_eff),
      .nab      (nab_w),
      .addr_al  (addr_al),
      .nxt_byte (nxt_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cpol_r  <= 1'b0;
         cpha_r  <= 1'b0;
         csh_r   <= 1'b0;
         nab_r   <= 2'd0;
         total_r <= '0;
         bidx    <= '0;
         addr_sh <= '0;
         sreg    <= '0;
         rx_sh   <= '0;
         rx_q    <= '0;
         bitc    <= '0;
         half_b  <= 1'b0;
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
         rxv_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         rxv_q  <= 1'b0;
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               sclk_q <= mode[BIT_POL];
               if (req) begin
                  cpol_r  <= mode[BIT_POL];
                  cpha_r  <= mode[BIT_PHA];
                  csh_r   <= mode[BIT_CSH];
                  nab_r   <= nab_w;
                  total_r <= CW'(1) + CW'(nab_w) + CW'(data_len);
                  addr_sh <= addr_al;
                  sreg    <= cmd_eff;
                  bidx    <= '0;
                  bitc    <= '0;
                  half_b  <= 1'b0;
                  cs_q    <= mode[BIT_CSH];
                  state   <= ST_SETUP;
               end else begin
                  cs_q    <= ~mode[BIT_CSH];
               end
            end
            ST_SETUP: begin
               if (tick) begin
                  state  <= ST_SHIFT;
                  half_b <= 1'b0;
                  sclk_q <= cpol_r ^ cpha_r;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!half_b) begin
                     half_b <= 1'b1;
                     rx_sh  <= {rx_sh[6:0], miso};
                     sclk_q <= cpol_r ^ ~cpha_r;
                  end else begin
                     half_b <= 1'b0;
                     if (bitc == 3'd7) begin
                        rxv_q <= cur_data;
                        rx_q  <= rx_sh;
                        if (last_byte) begin
                           state  <= ST_HOLD;
                           sclk_q <= cpol_r;
                        end else begin
                           bidx   <= bidx + CW'(1);
                           bitc   <= '0;
                           sreg   <= nxt_byte;
                           sclk_q <= cpol_r ^ cpha_r;
                           if (nxt_addr) addr_sh <= {addr_sh[15:0], 8'h00};
                        end
                     end else begin
                        bitc   <= bitc + 3'd1;
                        sreg   <= {sreg[6:0], 1'b0};
                        sclk_q <= cpol_r ^ cpha_r;
                     end
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  cs_q  <= ~csh_r;
                  state <= ST_FIN;
               end
            end
            ST_FIN: begin
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_mem_master_chk.sv
module spi_mem_master_chk (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic busy,
   input logic done,
   input logic rx_valid,
   input logic tx_take,
   input logic sclk,
   input logic mosi
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   rx_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> busy);

   // R7
   take_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> busy);

   // R4
   mosi_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mosi)) |-> !$stable(sclk));

   // R11
   busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req));
endmodule

bind spi_mem_master spi_mem_master_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req      (req),
   .busy     (busy),
   .done     (done),
   .rx_valid (rx_valid),
   .tx_take  (tx_take),
   .sclk     (sclk),
   .mosi     (mosi)
);

// File: tb/spi_mem_master_tb.sv
`timescale 1ns/100ps
module spi_mem_master_tb;
   localparam int CLK_DIV = 4;
   localparam int LEN_W   = 8;
   localparam int HALF    = CLK_DIV / 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req = 1'b0;
   logic [4:0]       mode = 5'd0;
   logic [7:0]       cmd = 8'd0;
   logic [23:0]      addr = 24'd0;
   logic [1:0]       addr_sel = 2'd0;
   logic             munge = 1'b0;
   logic [LEN_W-1:0] data_len = '0;
   logic [7:0]       tx_data = 8'd0;
   logic             miso = 1'b0;
   logic             tx_take, rx_valid, busy, done, sclk, mosi, cs;
   logic [7:0]       rx_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [7:0] exp_bytes [16];
   logic [7:0] txarr [16];
   logic [7:0] resp [16];
   logic [7:0] cap [16];
   logic [7:0] rxgot [16];
   logic [4:0] cur_mode = 5'd0;
   int cyc = 0, nsamp = 0, nedges = 0, tidx = 0, ridx = 0, ntake = 0;
   int act_cyc = 0, first_edge_cyc = 0, last_edge_cyc = 0, rel_cyc = 0, min_gap = 1000;

   always #2.5 clk = ~clk;

   spi_mem_master #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .cmd(cmd), .addr(addr),
      .addr_sel(addr_sel), .munge(munge), .data_len(data_len), .tx_data(tx_data),
      .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
      .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs)
   );

   function automatic logic bitof(int k);
      if (k >= 128) return 1'b0;
      return resp[k / 8][7 - (k % 8)];
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Slave model, transmit feeder and receive collector, all at the falling edge.
   initial begin
      bit act, prev_act, lead, samp;
      logic prev_sclk;
      prev_act = 0;
      prev_sclk = 0;
      forever begin
         @(negedge clk);
         cyc++;
         tx_data = txarr[tidx];
         if (tx_take === 1'b1) begin
            ntake++;
            if (tidx < 15) tidx++;
         end
         if (rx_valid === 1'b1) begin
            if (ridx < 16) rxgot[ridx] = rx_data;
            ridx++;
         end
         act = cur_mode[4] ? (cs === 1'b1) : (cs === 1'b0);
         if (act && !prev_act) begin
            nsamp = 0; nedges = 0; act_cyc = cyc; min_gap = 1000;
            if (!cur_mode[0]) miso = bitof(0);
         end
         if (!act && prev_act) rel_cyc = cyc;
         if (act && prev_act && sclk !== prev_sclk) begin
            if (nedges == 0) first_edge_cyc = cyc;
            else if (cyc - last_edge_cyc < min_gap) min_gap = cyc - last_edge_cyc;
            last_edge_cyc = cyc;
            nedges++;
            lead = (sclk !== cur_mode[1]);
            samp = cur_mode[0] ? !lead : lead;
            if (samp) begin
               if (nsamp < 128) cap[nsamp / 8][7 - (nsamp % 8)] = mosi;
               nsamp++;
            end else begin
               miso = bitof(nsamp);
            end
         end
         prev_act = act;
         prev_sclk = sclk;
      end
   end

   task automatic settle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic run_txn(input logic [4:0] m, input logic [7:0] c, input logic [23:0] a,
                          input logic [1:0] sel, input bit mg, input int len, input int inject);
      int nab, nexp, n, bad, rbad, seen_done;
      string tag;
      nab = (sel == 0) ? 0 : (mg ? 1 : int'(sel));
      nexp = 1 + nab + len;
      if (m != mode) begin
         mode = m;
         cur_mode = m;
         settle(3);
      end
      for (int i = 0; i < 16; i++) begin
         txarr[i] = 8'($urandom);
         resp[i]  = 8'($urandom);
         cap[i]   = 8'h00;
         rxgot[i] = 8'h00;
      end
      exp_bytes[0] = c | ((mg && sel != 0 && a[8]) ? 8'h08 : 8'h00);
      for (int i = 0; i < nab; i++) exp_bytes[1 + i] = 8'(a >> (8 * (nab - 1 - i)));
      for (int i = 0; i < len; i++) exp_bytes[1 + nab + i] = txarr[i];
      tidx = 0; ridx = 0; ntake = 0;
      cmd = c; addr = a; addr_sel = sel; munge = mg; data_len = LEN_W'(len);
      req = 1'b1;
      settle(1);
      req = 1'b0;
      chk(busy === 1'b1, "R10", "busy after request", busy, 1);
      n = 0;
      seen_done = 0;
      while (!seen_done && n < 4000) begin
         if (done === 1'b1) seen_done = 1;
         else begin
            settle(1);
            n++;
            if (inject != 0 && n == inject) begin req = 1'b1; cmd = ~c; end
            else if (inject != 0 && n == inject + 1) begin req = 1'b0; cmd = c; end
         end
      end
      chk(seen_done == 1, "R10", "done reached", n, 0);
      chk(cyc == rel_cyc + 1, "R10", "done one cycle after release", cyc - rel_cyc, 1);
      chk(busy === 1'b0, "R10", "busy low with done", busy, 0);
      tag = (mg && sel != 0) ? "R3" : ((len == 0) ? "R8" : "R2");
      if (inject != 0) tag = "R11";
      chk(nsamp == 8 * nexp, tag, "bits on bus", nsamp, 8 * nexp);
      bad = -1;
      for (int i = nexp - 1; i >= 0; i--) if (cap[i] !== exp_bytes[i]) bad = i;
      if (bad >= 0) chk(0, tag, $sformatf("mosi byte %0d mode %0d", bad, m), cap[bad], exp_bytes[bad]);
      else chk(1, tag, "mosi frame", 0, 0);
      chk(ridx == len, "R6", "rx_valid count", ridx, len);
      rbad = -1;
      for (int i = len - 1; i >= 0; i--) if (rxgot[i] !== resp[1 + nab + i]) rbad = i;
      if (rbad >= 0) chk(0, "R6", $sformatf("rx byte %0d mode %0d", rbad, m), rxgot[rbad], resp[1 + nab + rbad]);
      else chk(1, "R6", "rx bytes", 0, 0);
      chk(ntake == len, "R7", "tx_take count", ntake, len);
      chk(first_edge_cyc - act_cyc >= HALF, "R9", "select setup", first_edge_cyc - act_cyc, HALF);
      chk(rel_cyc - last_edge_cyc >= HALF, "R9", "select hold", rel_cyc - last_edge_cyc, HALF);
      chk(min_gap == HALF, "R9", "half period", min_gap, HALF);
      chk(sclk === m[1], "R4", "sclk idle level", sclk, m[1]);
      chk(cs === ~m[4], "R5", "cs inactive level", cs, ~m[4]);
   endtask

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      settle(4);
      chk(cs === 1'b1, "R1", "reset cs", cs, 1);
      chk(sclk === 1'b0, "R1", "reset sclk", sclk, 0);
      chk(done === 1'b0 && busy === 1'b0, "R1", "reset done/busy", {done, busy}, 0);
      rst_n = 1'b1;
      settle(2);
      chk(rx_valid === 1'b0 && tx_take === 1'b0, "R1", "idle strobes", {rx_valid, tx_take}, 0);
      mode = 5'h12;
      settle(2);
      chk(cs === 1'b0, "R1", "idle cs tracks mode", cs, 0);
      chk(sclk === 1'b1, "R1", "idle sclk tracks mode", sclk, 1);
      cur_mode = 5'h12;
      settle(1);
      // directed corners
      run_txn(5'h00, 8'h06, 24'h0, 2'd0, 0, 0, 0);          // R8 opcode only
      run_txn(5'h10, 8'h03, 24'h0001A5, 2'd1, 1, 3, 0);     // R3 fold, bit 8 set
      run_txn(5'h10, 8'h0B, 24'h0000A5, 2'd2, 1, 1, 0);     // R3 fold, bit 8 clear
      run_txn(5'h01, 8'h02, 24'h00BEEF, 2'd2, 0, 2, 0);     // R4 phase 1
      run_txn(5'h03, 8'h0B, 24'h123456, 2'd3, 0, 4, 0);     // R2 three address bytes
      run_txn(5'h12, 8'h05, 24'h0, 2'd0, 0, 1, 0);          // R5 active-high select
      run_txn(5'h02, 8'h03, 24'hABCDEF, 2'd3, 0, 6, 40);    // R11 stray req mid-frame
      settle(1);
      chk(done === 1'b0, "R10", "done width", done, 0);
      run_txn(5'h01, 8'h9F, 24'h00FF00, 2'd1, 0, 2, 0);     // R11 back to back pair
      run_txn(5'h01, 8'h5A, 24'h0000C3, 2'd2, 0, 1, 0);
      run_txn(5'h11, 8'h04, 24'h0, 2'd0, 0, 0, 0);          // R8 write-disable style
      for (int t = 0; t < 40; t++) begin
         logic [4:0] m;
         m = {1'($urandom), 2'b00, 2'($urandom)};
         run_txn(m, 8'($urandom), 24'($urandom), 2'($urandom), 1'($urandom),
                 int'($urandom % 7), 0);
         if (($urandom % 3) == 0) settle(int'($urandom % 4) + 1);
      end
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(150000 * 5);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule